// File: doc/BRIEF.md
# Mode-Aware Integer Add/Subtract Unit with Carry and Overflow Flags

This block performs integer addition and reversed subtraction for a 64-bit datapath that can also run in a 32-bit mode. One operand set is presented per cycle with an operation code. A register or a sign-extended immediate serves as the second operand. The carry status bit of the surrounding core comes in on `carry_in`. The sum and a set of status flags leave the block one clock later from registers.

Subtraction inverts the first operand and adds one, so B minus A is formed with a single adder. The extended forms consume the incoming carry. They can add B, an all-ones constant, or zero. This supports chained multi-word arithmetic and negation. The mode bit selects where carry and signed overflow are observed: at the top of the word, or at the top of its low half. The summary-overflow bit is sticky and is cleared only on request. An optional 4-bit condition field records a signed compare of the result against zero, together with the summary-overflow bit.

Top module: `mode_adder`

## Requirements
- R1: While `rst` is high at a clock edge, every output register is cleared to zero, including `valid_out`, `result`, all flags and `cr_out`.
- R2: The add forms follow the op code, where bit 0 is clear and bits 2:1 select the second addend. With select 0 the sum is A+B. With 1 it is A+B+carry_in. With 2 it is A+carry_in+all-ones. With 3 it is A+carry_in. The sum appears on `result` at the edge after `valid_in` is sampled.
- R3: Setting op bit 0 replaces A with its bitwise inverse, which gives the subtract-from forms. Op 1 gives NOT(A)+B+1. Op 3 gives NOT(A)+B+carry_in. Op 5 gives NOT(A)+all-ones+carry_in. Op 7 gives NOT(A)+carry_in.
- R4: When `use_imm` is high, the second addend of op codes 0 to 3 is `imm_in`, sign-extended to 64 bits. When both `use_imm` and `ra_zero` are high, A is the constant 0 and not `a_in`.
- R5: `ca_out` is updated by every valid operation. In 64-bit mode (`mode64`=1) it holds the carry out of bit 63. In 32-bit mode it holds the carry out of bit 31.
- R6: In 32-bit mode `result` still holds the full 64-bit sum; only the flags are restricted to the low half.
- R7: With `ovf_en` high, `ov_out` holds the signed overflow of the 64-bit sum in 64-bit mode, or of the low 32-bit sum in 32-bit mode. With `ovf_en` low a valid operation writes 0 to `ov_out`.
- R8: `so_out` is set by any valid operation whose `ov_out` becomes 1, and arithmetic never clears it. It is cleared only by `so_clear`. If a clear and a new overflow fall in the same cycle, the set wins.
- R9: With `rec_en` high, a valid operation writes `cr_out`. Bit 3 is less-than, bit 2 is greater-than and bit 1 is equal, from a signed compare of the result with zero; only the low 32 bits are compared in 32-bit mode. Bit 0 is `so_out` after the same update. With `rec_en` low, `cr_out` keeps its value.
- R10: Negating the most negative value with op 7 and carry_in=1 returns that same value and sets overflow when `ovf_en` is high. This holds for the 64-bit value in 64-bit mode and the 32-bit value in 32-bit mode.
- R11: With `valid_in` low, `result`, `ca_out`, `ov_out` and `cr_out` keep their values and `valid_out` goes low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and op code are valid this cycle |
| op | input | 3 | Bit 0: invert A; bits 2:1: second addend / carry source |
| mode64 | input | 1 | 1 = 64-bit flags, 0 = 32-bit flags |
| ovf_en | input | 1 | Enable overflow reporting |
| rec_en | input | 1 | Update the condition field |
| use_imm | input | 1 | Use the sign-extended immediate as B |
| ra_zero | input | 1 | With use_imm, take A as zero |
| a_in | input | 64 | First operand |
| b_in | input | 64 | Second operand (register form) |
| imm_in | input | 16 | Signed immediate |
| carry_in | input | 1 | Current carry status bit |
| so_clear | input | 1 | Clear the summary-overflow flag |
| valid_out | output | 1 | Result registered from a valid operation |
| result | output | 64 | Sum |
| ca_out | output | 1 | Carry flag |
| ov_out | output | 1 | Overflow flag |
| so_out | output | 1 | Sticky summary-overflow flag |
| cr_out | output | 4 | {LT, GT, EQ, SO} |

## Verification
Directed cases come first. All-ones plus one is run in both modes to separate a carry taken from bit 63 from one taken from bit 31. The largest positive value plus one is run in both modes to show where overflow is observed. Both most negative values are negated. Each of the eight op codes is run with carry_in at both values. The bench then runs long random sequences that mix modes, immediates, records, clears and idle cycles, and weights them toward boundary operands. These sequences expose errors in sticky-flag and hold behaviour that single operations cannot show. A behavioural model compares every output on every clock.

// File: rtl/mode_adder_pkg.sv
package mode_adder_pkg;
  // Source of the second addend, taken from op bits 2:1
  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_CARRY = 2'd1,
    SRC_ONES  = 2'd2,
    SRC_ZERO  = 2'd3
  } addend_src_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/mode_adder_opsel.sv
module mode_adder_opsel
  import mode_adder_pkg::*;
#(
  parameter int W    = 64,
  parameter int IMMW = 16
) (
  input  logic [2:0]      op,
  input  logic            use_imm,
  input  logic            ra_zero,
  input  logic [W-1:0]    a_in,
  input  logic [W-1:0]    b_in,
  input  logic [IMMW-1:0] imm_in,
  input  logic            carry_in,
  output logic [W-1:0]    x_op,
  output logic [W-1:0]    y_op,
  output logic            cin
);
  localparam int EXTW = W - IMMW;

  logic [W-1:0] imm_ext;
  logic [W-1:0] a_base;
  logic [W-1:0] b_base;
  addend_src_e  src;

  assign imm_ext = {{EXTW{imm_in[IMMW-1]}}, imm_in};
  assign src     = addend_src_e'(op[2:1]);

  always_comb begin
    a_base = (use_imm && ra_zero) ? '0 : a_in;
    b_base = use_imm ? imm_ext : b_in;
    x_op   = op[0] ? ~a_base : a_base;
    unique case (src)
      SRC_REG: begin
        y_op = b_base;
        cin  = op[0];
      end
      SRC_CARRY: begin
        y_op = b_base;
        cin  = carry_in;
      end
      SRC_ONES: begin
        y_op = '1;
        cin  = carry_in;
      end
      default: begin
        y_op = '0;
        cin  = carry_in;
      end
    endcase
  end
endmodule

// File: rtl/mode_adder_lanes.sv
module mode_adder_lanes #(
  parameter int W     = 64,
  parameter int LANES = 2
) (
  input  logic [W-1:0]     x_op,
  input  logic [W-1:0]     y_op,
  input  logic             cin,
  output logic [W-1:0]     sum,
  output logic [LANES-1:0] lane_cout
);
  localparam int LW = W / LANES;

  logic [LANES:0] chain;
  assign chain[0] = cin;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW:0] part;
    assign part = {1'b0, x_op[g*LW +: LW]} + {1'b0, y_op[g*LW +: LW]}
                + {{LW{1'b0}}, chain[g]};
    assign sum[g*LW +: LW] = part[LW-1:0];
    assign chain[g+1]      = part[LW];
  end

  assign lane_cout = chain[LANES:1];
endmodule

// File: rtl/mode_adder_flags.sv
module mode_adder_flags
  import mode_adder_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         mode64,
  input  logic [W-1:0] sum,
  input  logic [1:0]   lane_cout,
  input  logic [1:0]   x_sign,
  input  logic [1:0]   y_sign,
  output logic         ca_n,
  output logic         ov_raw,
  output logic         lt_n,
  output logic         gt_n,
  output logic         eq_n
);
  localparam int HALF = W / 2;

  logic ov_full;
  logic ov_half;
  logic zero_full;
  logic zero_half;

  // x_sign/y_sign: bit 1 = top of word, bit 0 = top of low half
  assign ov_full   = (x_sign[1] == y_sign[1]) && (sum[W-1]    != x_sign[1]);
  assign ov_half   = (x_sign[0] == y_sign[0]) && (sum[HALF-1] != x_sign[0]);
  assign zero_full = (sum == '0);
  assign zero_half = (sum[HALF-1:0] == '0);

  always_comb begin
    if (mode64) begin
      ca_n   = lane_cout[1];
      ov_raw = ov_full;
      lt_n   = sum[W-1];
      eq_n   = zero_full;
    end else begin
      ca_n   = lane_cout[0];
      ov_raw = ov_half;
      lt_n   = sum[HALF-1];
      eq_n   = zero_half;
    end
    gt_n = !lt_n && !eq_n;
  end
endmodule

// File: rtl/mode_adder.sv
module mode_adder
  import mode_adder_pkg::*;
#(
  parameter int W    = 64,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_in,
  input  logic [2:0]      op,
  input  logic            mode64,
  input  logic            ovf_en,
  input  logic            rec_en,
  input  logic            use_imm,
  input  logic            ra_zero,
  input  logic [W-1:0]    a_in,
  input  logic [W-1:0]    b_in,
  input  logic [IMMW-1:0] imm_in,
  input  logic            carry_in,
  input  logic            so_clear,
  output logic            valid_out,
  output logic [W-1:0]    result,
  output logic            ca_out,
  output logic            ov_out,
  output logic            so_out,
  output logic [3:0]      cr_out
);
  localparam int HALF = W / 2;

  logic [W-1:0] x_op;
  logic [W-1:0] y_op;
  logic         cin;
  logic [W-1:0] sum;
  logic [1:0]   lane_cout;
  logic         ca_n, ov_raw, lt_n, gt_n, eq_n;
  logic         so_n;

  logic         vld_q;
  logic [W-1:0] res_q;
  logic         ca_q;
  logic         ov_q;
  logic         so_q;
  cond_t        cr_q;

  mode_adder_opsel #(.W(W), .IMMW(IMMW)) u_opsel (
    .op       (op),
    .use_imm  (use_imm),
    .ra_zero  (ra_zero),
    .a_in     (a_in),
    .b_in     (b_in),
    .imm_in   (imm_in),
    .carry_in (carry_in),
    .x_op     (x_op),
    .y_op     (y_op),
    .cin      (cin)
  );

  mode_adder_lanes #(.W(W), .LANES(2)) u_lanes (
    .x_op      (x_op),
    .y_op      (y_op),
    .cin       (cin),
    .sum       (sum),
    .lane_cout (lane_cout)
  );

  mode_adder_flags #(.W(W)) u_flags (
    .mode64    (mode64),
    .sum       (sum),
    .lane_cout (lane_cout),
    .x_sign    ({x_op[W-1], x_op[HALF-1]}),
    .y_sign    ({y_op[W-1], y_op[HALF-1]}),
    .ca_n      (ca_n),
    .ov_raw    (ov_raw),
    .lt_n      (lt_n),
    .gt_n      (gt_n),
    .eq_n      (eq_n)
  );

  // Sticky flag: clear first, a new overflow in the same cycle sets it again
  assign so_n = (so_q && !so_clear) || (valid_in && ovf_en && ov_raw);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      res_q <= '0;
      ca_q  <= 1'b0;
      ov_q  <= 1'b0;
      so_q  <= 1'b0;
      cr_q  <= '0;
    end else begin
      vld_q <= valid_in;
      so_q  <= so_n;
      if (valid_in) begin
        res_q <= sum;
        ca_q  <= ca_n;
        ov_q  <= ovf_en && ov_raw;
        if (rec_en) begin
          cr_q <= '{lt: lt_n, gt: gt_n, eq: eq_n, so: so_n};
        end
      end
    end
  end

  assign valid_out = vld_q;
  assign result    = res_q;
  assign ca_out    = ca_q;
  assign ov_out    = ov_q;
  assign so_out    = so_q;
  assign cr_out    = cr_q;

  AST_OV_GATED: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !ovf_en) |=> !ov_out); // R7
  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (so_out && !so_clear) |=> so_out); // R8
  AST_OV_SETS_SO: assert property (@(posedge clk) disable iff (rst)
    (valid_in && ovf_en) |=> (!ov_out || so_out)); // R8
  AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (rst)
    (valid_in && rec_en) |=> (cr_out[0] == so_out)); // R9
  AST_CR_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    (valid_in && rec_en) |=> ($countones(cr_out[3:1]) == 1)); // R9
  AST_CR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(valid_in && rec_en) |=> $stable(cr_out[3:1])); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(result) && $stable(ca_out) && !valid_out)); // R11
endmodule

// File: tb/mode_adder_test.sv
`timescale 1ns/1ps
module mode_adder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_in;
  logic [2:0]  op;
  logic        mode64, ovf_en, rec_en, use_imm, ra_zero, carry_in, so_clear;
  logic [63:0] a_in, b_in;
  logic [15:0] imm_in;
  logic        valid_out, ca_out, ov_out, so_out;
  logic [63:0] result;
  logic [3:0]  cr_out;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic        e_vld, e_ca, e_ov, e_so;
  logic [63:0] e_res;
  logic [3:0]  e_cr;
  logic        last_ovraw;

  always #2.5 clk = ~clk;

  mode_adder uut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op(op), .mode64(mode64),
    .ovf_en(ovf_en), .rec_en(rec_en), .use_imm(use_imm), .ra_zero(ra_zero),
    .a_in(a_in), .b_in(b_in), .imm_in(imm_in), .carry_in(carry_in),
    .so_clear(so_clear), .valid_out(valid_out), .result(result),
    .ca_out(ca_out), .ov_out(ov_out), .so_out(so_out), .cr_out(cr_out)
  );

  task automatic chk(input string tg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic compare_all(input string rtag);
    chk("R11 valid_out", {63'b0, valid_out}, {63'b0, e_vld});
    chk(rtag, result, e_res);
    chk("R5 ca_out", {63'b0, ca_out}, {63'b0, e_ca});
    chk("R7 ov_out", {63'b0, ov_out}, {63'b0, e_ov});
    chk("R8 so_out", {63'b0, so_out}, {63'b0, e_so});
    chk("R9 cr_out", {60'b0, cr_out}, {60'b0, e_cr});
  endtask

  // one operation: drive at negedge, model, wait one edge, compare at next negedge
  task automatic step(input logic v, input logic [2:0] o, input logic m64,
                      input logic oe, input logic rc, input logic ui,
                      input logic rz, input logic [63:0] ia, input logic [63:0] ib,
                      input logic [15:0] im, input logic ci, input logic clr);
    logic [63:0] x, y, bsel;
    logic        c, ovr, lt, eq;
    logic [64:0] full;
    logic [32:0] lo;
    string       rtag;
    valid_in = v; op = o; mode64 = m64; ovf_en = oe; rec_en = rc;
    use_imm = ui; ra_zero = rz; a_in = ia; b_in = ib; imm_in = im;
    carry_in = ci; so_clear = clr;
    x    = (ui && rz) ? 64'd0 : ia;
    if (o[0]) x = ~x;
    bsel = ui ? {{48{im[15]}}, im} : ib;
    case (o[2:1])
      2'd0:    begin y = bsel;   c = o[0]; end
      2'd1:    begin y = bsel;   c = ci;   end
      2'd2:    begin y = '1;     c = ci;   end
      default: begin y = 64'd0;  c = ci;   end
    endcase
    full = {1'b0, x} + {1'b0, y} + {64'd0, c};
    lo   = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'd0, c};
    if (m64) begin
      ovr = (x[63] == y[63]) && (full[63] != x[63]);
      lt  = full[63];
      eq  = (full[63:0] == 64'd0);
    end else begin
      ovr = (x[31] == y[31]) && (full[31] != x[31]);
      lt  = full[31];
      eq  = (full[31:0] == 32'd0);
    end
    last_ovraw = ovr;
    e_so  = (e_so && !clr) || (v && oe && ovr);
    e_vld = v;
    if (v) begin
      e_res = full[63:0];
      e_ca  = m64 ? full[64] : lo[32];
      e_ov  = oe && ovr;
      if (rc) e_cr = {lt, !lt && !eq, eq, e_so};
    end
    if (!v)          rtag = "R11 result hold";
    else if (ui)     rtag = "R4 result";
    else if (!m64)   rtag = "R6 result";
    else if (o[0])   rtag = "R3 result";
    else             rtag = "R2 result";
    @(posedge clk);
    @(negedge clk);
    compare_all(rtag);
  endtask

  function automatic logic [63:0] pick64();
    case ($urandom_range(0, 7))
      0: return 64'h8000_0000_0000_0000;
      1: return 64'h7FFF_FFFF_FFFF_FFFF;
      2: return '1;
      3: return 64'h0000_0000_8000_0000;
      4: return 64'h0000_0000_7FFF_FFFF;
      5: return 64'h0000_0000_FFFF_FFFF;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_in = 0; op = 0; mode64 = 1; ovf_en = 0; rec_en = 0;
    use_imm = 0; ra_zero = 0; a_in = 0; b_in = 0; imm_in = 0;
    carry_in = 0; so_clear = 0;
    e_vld = 0; e_ca = 0; e_ov = 0; e_so = 0; e_res = 0; e_cr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 valid_out", {63'b0, valid_out}, 64'd0);
    chk("R1 result", result, 64'd0);
    chk("R1 flags", {60'b0, ca_out, ov_out, so_out, 1'b0}, 64'd0);
    chk("R1 cr_out", {60'b0, cr_out}, 64'd0);
    rst = 1'b0;

    // R2 plain add, 64-bit carry out
    step(1, 3'd0, 1, 1, 1, 0, 0, '1, 64'd1, 0, 0, 0);
    chk("R5 carry64", {63'b0, ca_out}, 64'd1);
    // R5/R6 32-bit mode carry out of bit 31, upper bits keep full sum
    step(1, 3'd0, 0, 1, 1, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 0);
    chk("R6 upper bits", result, 64'h0000_0001_0000_0000);
    chk("R5 carry32", {63'b0, ca_out}, 64'd1);
    // R7 overflow 64 and 32
    step(1, 3'd0, 1, 1, 1, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);
    chk("R7 ov64", {63'b0, ov_out}, 64'd1);
    step(1, 3'd0, 0, 1, 1, 0, 0, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0, 0);
    chk("R7 ov32", {63'b0, ov_out}, 64'd1);
    // R8 sticky through a clean op, then clear
    step(1, 3'd0, 1, 1, 1, 0, 0, 64'd3, 64'd4, 0, 0, 0);
    chk("R8 sticky", {63'b0, so_out}, 64'd1);
    step(0, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 cleared", {63'b0, so_out}, 64'd0);
    // R7 overflow disabled
    step(1, 3'd0, 1, 0, 1, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);
    chk("R7 ov disabled", {63'b0, ov_out}, 64'd0);
    // R3 subtract-from: 10 - 3
    step(1, 3'd1, 1, 0, 1, 0, 0, 64'd3, 64'd10, 0, 0, 0);
    chk("R3 subf", result, 64'd7);
    // R4 immediate with zero A: loads -2
    step(1, 3'd0, 1, 0, 1, 1, 1, 64'd999, 64'd5, 16'hFFFE, 0, 0);
    chk("R4 load imm", result, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R9 negative", {60'b0, cr_out}, 64'h8);
    // R10 negation of most negative, 64 and 32-bit
    step(1, 3'd7, 1, 1, 1, 0, 0, 64'h8000_0000_0000_0000, 0, 0, 1, 1);
    chk("R10 neg64 result", result, 64'h8000_0000_0000_0000);
    chk("R10 neg64 ov", {63'b0, ov_out}, 64'd1);
    step(1, 3'd7, 0, 1, 1, 0, 0, 64'h0000_0000_8000_0000, 0, 0, 1, 1);
    chk("R10 neg32 low", {32'b0, result[31:0]}, 64'h8000_0000);
    chk("R10 neg32 ov", {63'b0, ov_out}, 64'd1);
    // every op code with carry_in both ways (R2, R3)
    for (int k = 0; k < 16; k++)
      step(1, 3'(k % 8), 1, 1, 1, 0, 0, 64'h1234_5678_9ABC_DEF0,
           64'h0FED_CBA9_8765_4321, 0, 1'(k / 8), 0);
    // R9 record disabled keeps cr
    step(1, 3'd0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 2000; n++) begin
      step(1'($urandom_range(0, 4) != 0), 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 1)), pick64(), pick64(),
           16'($urandom()), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 9) == 0));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule